// File: doc/BRIEF.md
# Descriptor Table Walking DMA Engine

This block is one bus-master channel. It walks a table of 8-byte region descriptors held in memory and moves the buffer that each descriptor names between memory and a device-side word stream. A pulse on `start` makes it begin at the table base. It reads each descriptor as two 32-bit words and checks that the buffer stays inside one 64 KiB window. It then transfers the buffer one 32-bit word at a time. When the descriptor carrying the end flag has been used up, it stops.

The direction is sampled at start and holds for the whole table. In memory-to-device mode, the engine reads memory and offers each word on the outgoing stream. In device-to-memory mode, it accepts words from the incoming stream and writes them to memory. The memory side carries a single request at a time. That request is held until the memory acknowledges it, and the acknowledge may carry an error flag. A completed table gives a one-cycle `done` pulse. A bad descriptor, a failed memory access, or a device stream whose length does not match the table gives a one-cycle `err` pulse. Raising `stop` abandons the table, and the position reached in the table is lost.

Top module: `prd_dma_engine`

## Requirements
- R1: After reset the engine is idle. `busy`, `mem_req`, `done`, `err`, `dev_in_ready` and `dev_out_valid` are all low.
- R2: A `start` pulse while idle makes `busy` rise on the next edge. The first two memory reads go to `table_base` and `table_base+4`. A `start` pulse while busy is ignored. A request that is not acknowledged stays asserted with the same address and type.
- R3: Each descriptor is laid out as follows: the first word read is the buffer address, bits 15:0 of the second word are the byte count, and bit 31 of the second word is the end-of-table flag. A byte count of zero stands for 65536 bytes.
- R4: With `to_mem`=0, the buffer is read at consecutive word addresses. Each word read is offered on `dev_out_data` under a valid/ready handshake. `dev_out_last` is high only on the final word of the table.
- R5: With `to_mem`=1, each word accepted from the incoming stream is written, in order, to consecutive word addresses of the buffer.
- R6: When a descriptor without the end flag finishes, the next descriptor is fetched from `table_base + 8*index`.
- R7: `done` pulses for exactly one cycle after the final word of the descriptor carrying the end flag. `busy` falls on the same edge.
- R8: A descriptor whose buffer would cross a 64 KiB address boundary ends the table with `err` and no data access. A buffer that ends exactly at a boundary is legal.
- R9: In device-to-memory mode, an incoming word whose `dev_in_last` does not match "final word of the table" ends the table with `err`. This covers both a stream that is too short and one that is too long.
- R10: A memory acknowledge flagged with `mem_err`, on either a descriptor fetch or a data access, ends the table with `err` and no `done`.
- R11: `stop` while busy returns the engine to idle on the next edge, with neither `done` nor `err`. The next `start` begins again at descriptor 0.
- R12: The direction is captured at `start`. Changing `to_mem` while busy has no effect on the current table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking the table from descriptor 0 |
| stop | input | 1 | Abandon the current table |
| to_mem | input | 1 | 1: device stream to memory, 0: memory to device stream |
| table_base | input | 32 | Byte address of descriptor 0 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Access failed, valid with `mem_ack` |
| dev_in_valid | input | 1 | Incoming stream word valid |
| dev_in_ready | output | 1 | Engine accepts an incoming word |
| dev_in_data | input | 32 | Incoming word |
| dev_in_last | input | 1 | Device marks its final word |
| dev_out_valid | output | 1 | Outgoing word valid |
| dev_out_ready | input | 1 | Device accepts the outgoing word |
| dev_out_data | output | 32 | Outgoing word |
| dev_out_last | output | 1 | Outgoing word is the table's final word |
| busy | output | 1 | Engine is walking a table |
| done | output | 1 | One-cycle table-complete pulse |
| err | output | 1 | One-cycle table-failed pulse |

## Verification
Several rules are checked by assertions on every cycle. A pending memory request keeps its address and type until it is acknowledged. `done` and `err` never coincide with `busy`. A start from idle always raises `busy`. `stop` always empties the engine on the next edge. The captured direction never changes mid-table. Other behaviour can only be shown by the bench's scenarios, which compare the exact address order of fetches and data accesses, the stream contents and the placement of the last marker against values worked out from the descriptors. The same scenarios cover the 64 KiB zero-count buffer, a buffer ending exactly on a boundary versus one crossing it, short and long device streams, and a restart from descriptor 0 after an abort.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_FETCH_LO = 3'd1,
        ST_FETCH_HI = 3'd2,
        ST_CHECK    = 3'd3,
        ST_MOVE_A   = 3'd4,
        ST_MOVE_B   = 3'd5
    } dma_st_e;

    localparam int DESC_SHIFT = 3;   // 8 bytes per descriptor
endpackage

// File: rtl/prd_desc_check.sv
module prd_desc_check #(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int WORD_SH = $clog2(DATA_W / 8),
    parameter int WORDS_W = CNT_W + 1 - WORD_SH
) (
    input  logic [DATA_W-1:0]  buf_addr,
    input  logic [CNT_W-1:0]   byte_cnt,
    output logic [WORDS_W-1:0] words,
    output logic               crosses
);
    logic [CNT_W:0]    bytes;
    logic [DATA_W-1:0] last_byte;

    always_comb begin
        // zero count encodes the full window size
        bytes     = (byte_cnt == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, byte_cnt};
        last_byte = buf_addr + DATA_W'(bytes) - DATA_W'(1);
        crosses   = last_byte[DATA_W-1:CNT_W] != buf_addr[DATA_W-1:CNT_W];
        words     = bytes[CNT_W:WORD_SH];
    end
endmodule

// File: rtl/prd_mem_port.sv
module prd_mem_port
    import prd_dma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 13
) (
    input  dma_st_e           st,
    input  logic              dir,
    input  logic [DATA_W-1:0] table_base,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              table_end,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic              dev_out_last
);
    logic [DATA_W-1:0] desc_addr;

    always_comb begin
        desc_addr     = table_base + {{(DATA_W-IDX_W-DESC_SHIFT){1'b0}}, idx, {DESC_SHIFT{1'b0}}};
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = '0;
        mem_wdata     = data;
        dev_in_ready  = 1'b0;
        dev_out_valid = 1'b0;
        dev_out_last  = 1'b0;
        unique case (st)
            ST_FETCH_LO: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr;
            end
            ST_FETCH_HI: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + DATA_W'(4);
            end
            ST_MOVE_A: begin
                if (dir) begin
                    dev_in_ready = 1'b1;
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = addr;
                end
            end
            ST_MOVE_B: begin
                if (dir) begin
                    mem_req  = 1'b1;
                    mem_we   = 1'b1;
                    mem_addr = addr;
                end else begin
                    dev_out_valid = 1'b1;
                    dev_out_last  = table_end;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
    import prd_dma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int IDX_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              to_mem,
    input  logic [DATA_W-1:0] table_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    input  logic              dev_in_valid,
    output logic              dev_in_ready,
    input  logic [DATA_W-1:0] dev_in_data,
    input  logic              dev_in_last,
    output logic              dev_out_valid,
    input  logic              dev_out_ready,
    output logic [DATA_W-1:0] dev_out_data,
    output logic              dev_out_last,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int WORD_SH = $clog2(DATA_W / 8);
    localparam int WORDS_W = CNT_W + 1 - WORD_SH;

    typedef struct packed {
        dma_st_e            st;
        logic               dir;
        logic [IDX_W-1:0]   idx;
        logic [DATA_W-1:0]  lo;
        logic [CNT_W-1:0]   cnt;
        logic               lflag;
        logic [DATA_W-1:0]  addr;
        logic [WORDS_W-1:0] words;
        logic               last;
        logic [DATA_W-1:0]  data;
        logic               done;
        logic               err;
    } eng_state_t;

    eng_state_t q, d;
    logic [WORDS_W-1:0] ck_words;
    logic ck_crosses, fin_word, table_end, step, fail;

    prd_desc_check #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_check (
        .buf_addr (q.lo),
        .byte_cnt (q.cnt),
        .words    (ck_words),
        .crosses  (ck_crosses)
    );

    assign fin_word  = q.words == WORDS_W'(1);
    assign table_end = fin_word && q.last;

    prd_mem_port #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_port (
        .st            (q.st),
        .dir           (q.dir),
        .table_base    (table_base),
        .idx           (q.idx),
        .addr          (q.addr),
        .data          (q.data),
        .table_end     (table_end),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .dev_in_ready  (dev_in_ready),
        .dev_out_valid (dev_out_valid),
        .dev_out_last  (dev_out_last)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        step   = 1'b0;
        fail   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start && !stop) begin
                    d.st  = ST_FETCH_LO;
                    d.idx = '0;
                    d.dir = to_mem;
                end
            end
            ST_FETCH_LO: begin
                if (mem_ack) begin
                    fail = mem_err;
                    d.lo = mem_rdata;
                    d.st = ST_FETCH_HI;
                end
            end
            ST_FETCH_HI: begin
                if (mem_ack) begin
                    fail    = mem_err;
                    d.cnt   = mem_rdata[CNT_W-1:0];
                    d.lflag = mem_rdata[DATA_W-1];
                    d.st    = ST_CHECK;
                end
            end
            ST_CHECK: begin
                fail    = ck_crosses;
                d.addr  = q.lo;
                d.words = ck_words;
                d.last  = q.lflag;
                d.st    = ST_MOVE_A;
            end
            ST_MOVE_A: begin
                if (q.dir) begin
                    if (dev_in_valid) begin
                        fail   = dev_in_last != table_end;
                        d.data = dev_in_data;
                        d.st   = ST_MOVE_B;
                    end
                end else if (mem_ack) begin
                    fail   = mem_err;
                    d.data = mem_rdata;
                    d.st   = ST_MOVE_B;
                end
            end
            ST_MOVE_B: begin
                if (q.dir) begin
                    fail = mem_ack && mem_err;
                    step = mem_ack && !mem_err;
                end else begin
                    step = dev_out_ready;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (step) begin
            d.words = q.words - WORDS_W'(1);
            d.addr  = q.addr + DATA_W'(DATA_W / 8);
            if (!fin_word) begin
                d.st = ST_MOVE_A;
            end else if (q.last) begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end else begin
                d.idx = q.idx + IDX_W'(1);
                d.st  = ST_FETCH_LO;
            end
        end
        if (fail) begin
            d.st  = ST_IDLE;
            d.err = 1'b1;
        end
        if (stop && q.st != ST_IDLE) begin
            d.st   = ST_IDLE;
            d.done = 1'b0;
            d.err  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy         = q.st != ST_IDLE;
    assign done         = q.done;
    assign err          = q.err;
    assign dev_out_data = q.data;

    // R2: an unanswered request is held unchanged
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !stop) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R2: start from idle engages the engine
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !stop) |=> busy);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !err));

    p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    p_stop_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop) |=> (!busy && !done && !err));

    p_dir_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(q.dir)));
endmodule

// File: tb/prd_dma_engine_tb_top.sv
`timescale 1ns/1ps
module prd_dma_engine_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, stop = 1'b0, to_mem = 1'b0;
    logic [31:0] table_base = 32'h0000_1000;
    logic mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic dev_in_valid, dev_in_ready, dev_in_last;
    logic [31:0] dev_in_data;
    logic dev_out_valid, dev_out_ready, dev_out_last;
    logic [31:0] dev_out_data;
    logic busy, done, err;

    always #2.5 clk = ~clk;

    prd_dma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .to_mem(to_mem),
        .table_base(table_base), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .dev_in_valid(dev_in_valid),
        .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data),
        .dev_in_last(dev_in_last), .dev_out_valid(dev_out_valid),
        .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
        .dev_out_last(dev_out_last), .busy(busy), .done(done), .err(err)
    );

    // memory model
    logic [63:0] desc_mem [8];
    logic        err_on = 1'b0;
    logic [31:0] err_addr = '0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'h5A5A_5A5A;
    endfunction

    function automatic logic [31:0] rd(input logic [31:0] a);
        logic [63:0] dsc;
        if (a >= 32'h1000 && a < 32'h1040) begin
            dsc = desc_mem[int'((a - 32'h1000) >> 3)];
            return a[2] ? dsc[63:32] : dsc[31:0];
        end
        return pat(a);
    endfunction

    function automatic logic [63:0] mk(input logic lst, input logic [15:0] cnt, input logic [31:0] a);
        return {lst, 15'd0, cnt, a};
    endfunction

    assign mem_ack   = mem_req;
    assign mem_err   = mem_req && err_on && (mem_addr == err_addr);
    assign mem_rdata = rd(mem_addr);

    // device source
    int   src_len = 0;
    int   src_idx = 0;
    logic src_clr = 1'b0;
    logic gap_en = 1'b0;
    int   cyc = 0;
    assign dev_in_valid  = src_idx < src_len;
    assign dev_in_data   = 32'hC0DE_0000 + src_idx;
    assign dev_in_last   = src_idx == src_len - 1;
    assign dev_out_ready = !gap_en || cyc[0];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (src_clr) src_idx <= 0;
        else if (dev_in_valid && dev_in_ready) src_idx <= src_idx + 1;
    end

    // observers
    logic [31:0] rd_log [64];
    logic [31:0] wr_a [64];
    logic [31:0] wr_d [64];
    logic [31:0] out_d [64];
    int rd_n, wr_n, out_n, last_n, last_at, done_n, err_n;
    logic log_clr = 1'b0;

    always @(posedge clk) begin
        if (log_clr) begin
            rd_n = 0; wr_n = 0; out_n = 0; last_n = 0; last_at = -1; done_n = 0; err_n = 0;
        end else begin
            if (mem_req && mem_ack) begin
                if (!mem_we) begin
                    if (rd_n < 64) rd_log[rd_n] = mem_addr;
                    rd_n++;
                end else begin
                    if (wr_n < 64) begin wr_a[wr_n] = mem_addr; wr_d[wr_n] = mem_wdata; end
                    wr_n++;
                end
            end
            if (dev_out_valid && dev_out_ready) begin
                if (out_n < 64) out_d[out_n] = dev_out_data;
                if (dev_out_last) begin last_n++; last_at = out_n; end
                out_n++;
            end
            if (done) done_n++;
            if (err) err_n++;
        end
    end

    int tests = 0, fails = 0;
    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear();
        @(negedge clk); log_clr = 1'b1; src_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0; src_clr = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    logic busy_at_end;
    task automatic wait_end(input int lim);
        busy_at_end = 1'b1;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (done || err) begin busy_at_end = busy; break; end
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !mem_req && !done && !err && !dev_in_ready && !dev_out_valid,
            "R1", "idle outputs", {busy, mem_req, done, err, dev_in_ready, dev_out_valid}, 0);
    endtask

    task automatic t_out_two();
        logic [31:0] exp_rd [10];
        logic [31:0] exp_out [6];
        exp_rd = '{32'h1000, 32'h1004, 32'h20000, 32'h20004, 32'h20008, 32'h2000C,
                   32'h1008, 32'h100C, 32'h30100, 32'h30104};
        exp_out = '{32'h20000, 32'h20004, 32'h20008, 32'h2000C, 32'h30100, 32'h30104};
        desc_mem[0] = mk(1'b0, 16'd16, 32'h0002_0000);
        desc_mem[1] = mk(1'b1, 16'd8, 32'h0003_0100);
        to_mem = 1'b0; gap_en = 1'b1;
        clear();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy, "R2", "busy after start", busy, 1);
        wait_end(200);
        gap_en = 1'b0;
        chk(rd_n == 10, "R6", "read count", rd_n, 10);
        for (int i = 0; i < 10; i++)
            chk(rd_log[i] == exp_rd[i], (i < 2) ? "R2" : "R6", "read order", rd_log[i], exp_rd[i]);
        chk(out_n == 6, "R4", "words out", out_n, 6);
        for (int i = 0; i < 6; i++)
            chk(out_d[i] == pat(exp_out[i]), "R4", "out data", out_d[i], pat(exp_out[i]));
        chk(last_n == 1 && last_at == 5, "R4", "last position", last_at, 5);
        chk(done_n == 1 && err_n == 0, "R7", "one done pulse", done_n, 1);
        chk(!busy_at_end, "R7", "busy low with done", busy_at_end, 0);
    endtask

    task automatic t_in();
        desc_mem[0] = mk(1'b1, 16'd12, 32'h0004_0000);
        clear();
        src_len = 3; to_mem = 1'b1;
        kick();
        to_mem = 1'b0;   // R12: change while busy
        wait_end(200);
        chk(wr_n == 3 && rd_n == 2, "R12", "writes despite direction flip", wr_n, 3);
        for (int i = 0; i < 3; i++) begin
            chk(wr_a[i] == 32'h40000 + 4 * i, "R5", "write address", wr_a[i], 32'h40000 + 4 * i);
            chk(wr_d[i] == 32'hC0DE_0000 + i, "R5", "write data", wr_d[i], 32'hC0DE_0000 + i);
        end
        chk(done_n == 1 && err_n == 0, "R5", "done after writes", done_n, 1);
    endtask

    task automatic t_len_mismatch();
        desc_mem[0] = mk(1'b1, 16'd12, 32'h0004_0000);
        clear(); src_len = 2; to_mem = 1'b1;
        kick(); wait_end(200);
        chk(err_n == 1 && done_n == 0, "R9", "short stream error", err_n, 1);
        chk(wr_n == 1, "R9", "short stream writes", wr_n, 1);
        clear(); src_len = 4; to_mem = 1'b1;
        kick(); wait_end(200);
        chk(err_n == 1 && done_n == 0, "R9", "long stream error", err_n, 1);
        chk(wr_n == 2, "R9", "long stream writes", wr_n, 2);
        src_len = 0; to_mem = 1'b0;
    endtask

    task automatic t_boundary();
        desc_mem[0] = mk(1'b1, 16'd16, 32'h0005_FFF8);
        clear(); kick(); wait_end(200);
        chk(err_n == 1 && done_n == 0, "R8", "crossing rejected", err_n, 1);
        chk(rd_n == 2 && out_n == 0, "R8", "no data access", rd_n, 2);
        desc_mem[0] = mk(1'b1, 16'd16, 32'h0005_FFF0);
        clear(); kick(); wait_end(200);
        chk(done_n == 1 && err_n == 0 && out_n == 4, "R8", "exact fit accepted", out_n, 4);
    endtask

    task automatic t_zero_count();
        desc_mem[0] = mk(1'b1, 16'd0, 32'h0006_0000);
        clear(); kick(); wait_end(40000);
        chk(out_n == 16384, "R3", "zero count words", out_n, 16384);
        chk(last_n == 1 && last_at == 16383, "R3", "zero count last", last_at, 16383);
        chk(done_n == 1 && err_n == 0, "R3", "zero count done", done_n, 1);
    endtask

    task automatic t_mem_err();
        desc_mem[0] = mk(1'b1, 16'd16, 32'h0002_0000);
        err_on = 1'b1; err_addr = 32'h0002_0004;
        clear(); kick(); wait_end(200);
        chk(err_n == 1 && done_n == 0 && out_n == 1, "R10", "data read error", out_n, 1);
        err_addr = 32'h0000_1004;
        clear(); kick(); wait_end(200);
        chk(err_n == 1 && done_n == 0 && out_n == 0, "R10", "fetch error", err_n, 1);
        err_on = 1'b0;
    endtask

    task automatic t_stop();
        int hits;
        desc_mem[0] = mk(1'b1, 16'd0, 32'h0006_0000);
        clear(); kick();
        repeat (20) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;   // ignored while busy
        repeat (20) @(negedge clk);
        hits = 0;
        for (int i = 0; i < 64 && i < rd_n; i++) if (rd_log[i] == 32'h1000) hits++;
        chk(hits == 1, "R2", "start while busy ignored", hits, 1);
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        chk(!busy, "R11", "idle after stop", busy, 0);
        repeat (5) @(negedge clk);
        chk(done_n == 0 && err_n == 0 && !busy, "R11", "no pulse on stop", done_n + err_n, 0);
        desc_mem[0] = mk(1'b1, 16'd8, 32'h0002_0000);
        clear(); kick(); wait_end(200);
        chk(rd_log[0] == 32'h1000 && done_n == 1, "R11", "restart at descriptor 0", rd_log[0], 32'h1000);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) desc_mem[i] = '0;
        log_clr = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; log_clr = 1'b0;
        t_reset();
        t_out_two();
        t_in();
        t_len_mismatch();
        t_boundary();
        t_zero_count();
        t_mem_err();
        t_stop();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule